// File: doc/BRIEF.md
# Scanned Shared-Bus Read Controller

This block lets several processors read single words from several memories over one shared bus. Each transfer is a chain of fully interlocked handshakes. A processor places a memory index and a word address on its request inputs and raises its bus-request line. The block copies both values into a request register kept for that processor alone. A scanner polls the processors one per cycle and hands the bus to the first one it finds that has a captured request whose target memory is idle.

Once the bus is seized, the block copies the word address into the memory-side address register and raises the request line of the chosen memory. The memory returns the word together with its read-done line. The block then moves the word into the bus data register, drops the memory request and raises data-ready. The granted processor takes the word and drops its bus-request to close the transfer. The bus is not offered again until data-ready is low and the memory has lowered its read-done line. Polling resumes at the processor after the last one served.

Top module: `scanbus_read_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, busGrant, memReq and dataReady are all low and busData is zero.
- R2: A processor's memory index and word address are captured on the clock edge where its procBusReq is first seen high. Changes on procMemSel or procWordAddr while the request stays high have no effect on the transfer.
- R3: The scanner examines one processor index per cycle. A processor is granted only when its request has been captured and the memory it names is idle (its memRead bit low). When the bus is idle, the grant appears at most NPROC+1 cycles after procBusReq rises.
- R4: After a transfer for processor p completes, polling resumes at p+1 (wrapping to 0). With every processor requesting, grants therefore come in consecutive index order.
- R5: While p is granted, memAddr carries p's captured word address, and memReq has exactly bit m set, where m is p's captured memory index. memReq holds until memRead[m] is seen high.
- R6: One cycle after memRead[m] is sampled high, busData holds memWord slice m (bits m*DW +: DW), memReq is all low and dataReady is high.
- R7: dataReady stays high with busData unchanged until the granted processor's procBusReq is sampled low. dataReady is low in the following cycle.
- R8: No grant is issued while dataReady is high or while the memory of the previous transfer still has memRead high.
- R9: A requester whose target memory shows memRead high is skipped. Other requesters are served meanwhile, and it is granted once that memory is idle.
- R10: busGrant bit p marks processor p, and at most one bit of busGrant and at most one bit of memReq is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| procBusReq | input | NPROC | Bus-request line per processor |
| procMemSel | input | NPROC*MSW | Target memory index per processor, slice p*MSW +: MSW |
| procWordAddr | input | NPROC*AW | Word address per processor, slice p*AW +: AW |
| busGrant | output | NPROC | One-hot grant to the processor owning the bus |
| dataReady | output | 1 | Bus data register holds the returned word |
| busData | output | DW | Bus data register |
| memReq | output | NMEM | One-hot memory request |
| memAddr | output | AW | Word address register driven to the memories |
| memRead | input | NMEM | Per-memory read-done line |
| memWord | input | NMEM*DW | Per-memory data register, slice m*DW +: DW |

## Verification
The bench builds the block with four processors, three memories, 6-bit addresses and 16-bit words. At this size every processor/memory pairing can be swept at the lowest, highest and middle addresses, with memory latency, release delay and processor hold time all varied. Four processors against three memories force two requesters onto one memory, which exercises the idle-memory rule. The small processor count also lets the bench check the full round-robin order and the worst-case polling latency directly.

// File: rtl/scanbus_pkg.sv
`timescale 1ns/1ps
package scanbus_pkg;

  typedef enum logic [2:0] {
    PH_SCAN,
    PH_ADDR,
    PH_MREQ,
    PH_READY,
    PH_RECOVER
  } busPhase_t;

  typedef struct packed {
    logic latchTarget;
    logic captureWord;
  } dpStrobe_t;

endpackage

// File: rtl/scanbus_dp.sv
`timescale 1ns/1ps
module scanbus_dp
  import scanbus_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NMEM  = 3,
  parameter int AW    = 6,
  parameter int DW    = 16,
  localparam int PSW  = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int MSW  = (NMEM > 1) ? $clog2(NMEM) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NPROC-1:0]      procBusReq,
  input  logic [NPROC*MSW-1:0]  procMemSel,
  input  logic [NPROC*AW-1:0]   procWordAddr,
  input  logic [NMEM-1:0]       memRead,
  input  logic [NMEM*DW-1:0]    memWord,
  input  logic [PSW-1:0]        scanIdx,
  input  logic [PSW-1:0]        grantIdx,
  input  dpStrobe_t             strobe,
  output logic                  candOk,
  output logic                  selMemRead,
  output logic [MSW-1:0]        memSelIdx,
  output logic [AW-1:0]         memAddr,
  output logic [DW-1:0]         busData
);

  // per-processor request registers
  logic [NPROC-1:0] reqSeen;
  logic [MSW-1:0]   tgtMem  [NPROC];
  logic [AW-1:0]    tgtAddr [NPROC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqSeen <= '0;
      for (int p = 0; p < NPROC; p++) begin
        tgtMem[p]  <= '0;
        tgtAddr[p] <= '0;
      end
    end else begin
      reqSeen <= procBusReq;
      for (int p = 0; p < NPROC; p++) begin
        if (procBusReq[p] && !reqSeen[p]) begin
          tgtMem[p]  <= procMemSel[p*MSW +: MSW];
          tgtAddr[p] <= procWordAddr[p*AW +: AW];
        end
      end
    end
  end

  // candidate test for the processor under the scanner
  logic [MSW-1:0] candMem;
  logic           candBusy;

  always_comb begin
    candMem  = tgtMem[scanIdx];
    candBusy = 1'b1;              // out-of-range index never granted
    for (int m = 0; m < NMEM; m++) begin
      if (candMem == MSW'(m)) candBusy = memRead[m];
    end
    candOk = procBusReq[scanIdx] && reqSeen[scanIdx] && !candBusy;
  end

  // read-done of the memory being served
  always_comb begin
    selMemRead = 1'b0;
    for (int m = 0; m < NMEM; m++) begin
      if (memSelIdx == MSW'(m)) selMemRead = memRead[m];
    end
  end

  logic [DW-1:0] selWord;
  always_comb begin
    selWord = '0;
    for (int m = 0; m < NMEM; m++) begin
      if (memSelIdx == MSW'(m)) selWord = memWord[m*DW +: DW];
    end
  end

  // memory-side address register and bus data register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memSelIdx <= '0;
      memAddr   <= '0;
      busData   <= '0;
    end else begin
      if (strobe.latchTarget) begin
        memSelIdx <= tgtMem[grantIdx];
        memAddr   <= tgtAddr[grantIdx];
      end
      if (strobe.captureWord) busData <= selWord;
    end
  end

  // R2: the served address register only moves when a new target is latched
  p_addr_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchTarget |=> $stable(memAddr));

endmodule

// File: rtl/scanbus_ctrl.sv
`timescale 1ns/1ps
module scanbus_ctrl
  import scanbus_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NMEM  = 3,
  localparam int PSW  = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int MSW  = (NMEM > 1) ? $clog2(NMEM) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPROC-1:0] procBusReq,
  input  logic             candOk,
  input  logic             selMemRead,
  input  logic [MSW-1:0]   memSelIdx,
  output logic [PSW-1:0]   scanIdx,
  output logic [PSW-1:0]   grantIdx,
  output dpStrobe_t        strobe,
  output logic [NPROC-1:0] busGrant,
  output logic [NMEM-1:0]  memReq,
  output logic             dataReady
);

  localparam logic [PSW-1:0] LASTP = PSW'(NPROC - 1);

  busPhase_t      phase, phaseNext;
  logic [PSW-1:0] scanPtr, scanNext;
  logic [PSW-1:0] grantReg, grantNext;

  function automatic logic [PSW-1:0] succ(input logic [PSW-1:0] p);
    return (p == LASTP) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    phaseNext = phase;
    scanNext  = scanPtr;
    grantNext = grantReg;
    strobe    = '0;
    case (phase)
      PH_SCAN: begin
        if (candOk) begin
          grantNext = scanPtr;
          phaseNext = PH_ADDR;
        end else begin
          scanNext = succ(scanPtr);
        end
      end
      PH_ADDR: begin
        strobe.latchTarget = 1'b1;
        phaseNext          = PH_MREQ;
      end
      PH_MREQ: begin
        if (selMemRead) begin
          strobe.captureWord = 1'b1;
          phaseNext          = PH_READY;
        end
      end
      PH_READY: begin
        if (!procBusReq[grantReg]) phaseNext = PH_RECOVER;
      end
      PH_RECOVER: begin
        if (!selMemRead) begin
          phaseNext = PH_SCAN;
          scanNext  = succ(grantReg);
        end
      end
      default: phaseNext = PH_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_SCAN;
      scanPtr  <= '0;
      grantReg <= '0;
    end else begin
      phase    <= phaseNext;
      scanPtr  <= scanNext;
      grantReg <= grantNext;
    end
  end

  logic busOwned;
  assign busOwned  = (phase == PH_ADDR) || (phase == PH_MREQ) || (phase == PH_READY);
  assign dataReady = (phase == PH_READY);
  assign scanIdx   = scanPtr;
  assign grantIdx  = grantReg;

  for (genvar p = 0; p < NPROC; p++) begin : g_grant
    assign busGrant[p] = busOwned && (grantReg == PSW'(p));
  end

  for (genvar m = 0; m < NMEM; m++) begin : g_mreq
    assign memReq[m] = (phase == PH_MREQ) && (memSelIdx == MSW'(m));
  end

  // R10: grant and memory request are never shared
  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busGrant));
  p_memreq_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memReq));
  // R5: memory request is held until the memory answers
  p_memreq_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|memReq) && !selMemRead) |=> $stable(memReq));
  // R6: data-ready never coexists with a memory request
  p_ready_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> (memReq == '0));
  // R7: data-ready held while the owner still requests, dropped after release
  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && procBusReq[grantReg]) |=> dataReady);
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && !procBusReq[grantReg]) |=> !dataReady);
  // R8: a fresh grant only follows a quiet bus
  p_grant_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|busGrant) |-> !$past(dataReady));

endmodule

// File: rtl/scanbus_read_ctrl.sv
`timescale 1ns/1ps
module scanbus_read_ctrl
  import scanbus_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NMEM  = 3,
  parameter int AW    = 6,
  parameter int DW    = 16,
  localparam int PSW  = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int MSW  = (NMEM > 1) ? $clog2(NMEM) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NPROC-1:0]     procBusReq,
  input  logic [NPROC*MSW-1:0] procMemSel,
  input  logic [NPROC*AW-1:0]  procWordAddr,
  output logic [NPROC-1:0]     busGrant,
  output logic                 dataReady,
  output logic [DW-1:0]        busData,
  output logic [NMEM-1:0]      memReq,
  output logic [AW-1:0]        memAddr,
  input  logic [NMEM-1:0]      memRead,
  input  logic [NMEM*DW-1:0]   memWord
);

  dpStrobe_t      strobe;
  logic           candOk;
  logic           selMemRead;
  logic [MSW-1:0] memSelIdx;
  logic [PSW-1:0] scanIdx;
  logic [PSW-1:0] grantIdx;

  scanbus_ctrl #(.NPROC(NPROC), .NMEM(NMEM)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procBusReq (procBusReq),
    .candOk     (candOk),
    .selMemRead (selMemRead),
    .memSelIdx  (memSelIdx),
    .scanIdx    (scanIdx),
    .grantIdx   (grantIdx),
    .strobe     (strobe),
    .busGrant   (busGrant),
    .memReq     (memReq),
    .dataReady  (dataReady)
  );

  scanbus_dp #(.NPROC(NPROC), .NMEM(NMEM), .AW(AW), .DW(DW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .procBusReq   (procBusReq),
    .procMemSel   (procMemSel),
    .procWordAddr (procWordAddr),
    .memRead      (memRead),
    .memWord      (memWord),
    .scanIdx      (scanIdx),
    .grantIdx     (grantIdx),
    .strobe       (strobe),
    .candOk       (candOk),
    .selMemRead   (selMemRead),
    .memSelIdx    (memSelIdx),
    .memAddr      (memAddr),
    .busData      (busData)
  );

  // R7: the word handed to the processor stays put while offered
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> (!dataReady || $stable(busData)));

endmodule

// File: tb/scanbus_read_ctrl_tb.sv
`timescale 1ns/1ps
module scanbus_read_ctrl_tb;

  localparam int NPROC = 4;
  localparam int NMEM  = 3;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int MSW   = 2;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic           busReqB [NPROC];
  logic [MSW-1:0] selB    [NPROC];
  logic [AW-1:0]  addrB   [NPROC];

  logic [NPROC-1:0]     procBusReq;
  logic [NPROC*MSW-1:0] procMemSel;
  logic [NPROC*AW-1:0]  procWordAddr;
  logic [NPROC-1:0]     busGrant;
  logic                 dataReady;
  logic [DW-1:0]        busData;
  logic [NMEM-1:0]      memReq;
  logic [AW-1:0]        memAddr;
  logic [NMEM-1:0]      memRead;
  logic [NMEM*DW-1:0]   memWord;

  always_comb begin
    for (int p = 0; p < NPROC; p++) begin
      procBusReq[p]                = busReqB[p];
      procMemSel[p*MSW +: MSW]     = selB[p];
      procWordAddr[p*AW +: AW]     = addrB[p];
    end
  end

  scanbus_read_ctrl #(.NPROC(NPROC), .NMEM(NMEM), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN),
    .procBusReq(procBusReq), .procMemSel(procMemSel), .procWordAddr(procWordAddr),
    .busGrant(busGrant), .dataReady(dataReady), .busData(busData),
    .memReq(memReq), .memAddr(memAddr), .memRead(memRead), .memWord(memWord)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] wordOf(input int m, input int a);
    return DW'(((m + 1) * 32'h1357) ^ (a * 32'h0101) ^ 32'hA5);
  endfunction

  // memory models: latency and release delay, optional stuck-busy line
  logic [NMEM-1:0] memRdSt  = '0;
  logic [NMEM-1:0] holdBusy = '0;
  int latCnt  [NMEM];
  int dropCnt [NMEM];
  int dropDelay = 0;
  assign memRead = memRdSt | holdBusy;

  initial begin
    memWord = '0;
    for (int m = 0; m < NMEM; m++) begin latCnt[m] = 0; dropCnt[m] = 0; end
  end

  always @(posedge clk) begin
    #1;
    for (int m = 0; m < NMEM; m++) begin
      if (memReq[m] && !memRdSt[m]) begin
        if (latCnt[m] >= (int'(memAddr) + m) % 3) begin
          memRdSt[m] = 1'b1;
          memWord[m*DW +: DW] = wordOf(m, int'(memAddr));
          latCnt[m] = 0;
        end else latCnt[m]++;
      end else if (!memReq[m] && memRdSt[m]) begin
        if (dropCnt[m] >= dropDelay) begin
          memRdSt[m] = 1'b0;
          dropCnt[m] = 0;
        end else dropCnt[m]++;
      end
    end
  end

  // grant monitor
  int grantSeq [16];
  int nGrant = 0;
  int r8Viol = 0, r8Gap = 0, r9Viol = 0;
  logic [NPROC-1:0] prevGrant = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busGrant != '0 && prevGrant == '0) begin
        for (int p = 0; p < NPROC; p++)
          if (busGrant[p] && nGrant < 16) begin grantSeq[nGrant] = p; nGrant++; end
        check(!dataReady, "R8 grant while data-ready", longint'(dataReady), 0);
        check($countones(busGrant) == 1, "R10 grant one-hot", longint'(busGrant), 1);
      end
      if (busGrant[1] && memRead[2]) r8Viol++;
      if (memRead[2] && busGrant == '0 && !dataReady) r8Gap++;
      if (busGrant[0] && holdBusy[0]) r9Viol++;
    end
    prevGrant = busGrant;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  // one processor read with all handshake checks
  task automatic doRead(input int p, input int m, input int a, input int hold, input int maxWait);
    int waited;
    logic [DW-1:0] expW;
    expW = wordOf(m, a);
    @(negedge clk);
    selB[p] = MSW'(m); addrB[p] = AW'(a); busReqB[p] = 1'b1;
    @(negedge clk);
    selB[p] = MSW'((m + 1) % NMEM);      // R2: later input changes must not matter
    addrB[p] = AW'(a) ^ 6'h2A;
    waited = 1;
    while (!busGrant[p]) begin @(negedge clk); waited++; end
    if (maxWait > 0) check(waited <= maxWait, "R3 grant latency", waited, maxWait);
    while (memReq == '0) @(negedge clk);
    check(memReq == (NMEM'(1) << m), "R5 memReq target", longint'(memReq), longint'(NMEM'(1) << m));
    check(memAddr == AW'(a), "R5 R2 memAddr", longint'(memAddr), a);
    while (!memRead[m]) @(negedge clk);
    @(negedge clk);
    check(dataReady && memReq == '0, "R6 handover", {memReq, dataReady}, 1);
    check(busData == expW, "R6 R2 busData", longint'(busData), longint'(expW));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(dataReady && busData == expW, "R7 held word", longint'(busData), longint'(expW));
    end
    busReqB[p] = 1'b0;
    @(negedge clk);
    check(!dataReady && !busGrant[p], "R7 release", {busGrant, dataReady}, 0);
  endtask

  initial begin
    for (int p = 0; p < NPROC; p++) begin busReqB[p] = 1'b0; selB[p] = '0; addrB[p] = '0; end
    repeat (4) @(negedge clk);
    check(busGrant == '0 && memReq == '0 && !dataReady && busData == '0,
          "R1 reset outputs", {busData, busGrant, memReq, dataReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busGrant == '0 && memReq == '0 && !dataReady && busData == '0,
          "R1 after reset", {busData, busGrant, memReq, dataReady}, 0);

    // sweep: each processor, each memory, corner addresses
    for (int p = 0; p < NPROC; p++)
      for (int m = 0; m < NMEM; m++)
        for (int k = 0; k < 4; k++) begin
          int a;
          a = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 37 : 63;
          dropDelay = a % 2;
          doRead(p, m, a, (p + a) % 3, NPROC + 1);
          repeat (4) @(negedge clk);
        end
    dropDelay = 0;

    // R4: all processors contend, two reads each
    nGrant = 0;
    fork
      begin doRead(0, 0, 1, 0, 0); @(negedge clk); doRead(0, 1, 2, 1, 0); end
      begin doRead(1, 1, 4, 0, 0); @(negedge clk); doRead(1, 2, 7, 1, 0); end
      begin doRead(2, 2, 7, 0, 0); @(negedge clk); doRead(2, 0, 12, 1, 0); end
      begin doRead(3, 0, 10, 0, 0); @(negedge clk); doRead(3, 1, 17, 1, 0); end
    join
    check(nGrant == 8, "R4 grant count", nGrant, 8);
    for (int k = 0; k < 7; k++)
      check(grantSeq[k + 1] == (grantSeq[k] + 1) % NPROC, "R4 round-robin order",
            grantSeq[k + 1], (grantSeq[k] + 1) % NPROC);
    repeat (4) @(negedge clk);

    // R9: busy memory skipped, other requester served
    nGrant = 0; r9Viol = 0;
    @(negedge clk); holdBusy[0] = 1'b1;
    fork
      doRead(0, 0, 11, 0, 0);
      begin
        @(negedge clk);
        doRead(1, 1, 12, 0, NPROC + 1);
        repeat (20) @(negedge clk);
        check(busGrant[0] == 1'b0, "R9 busy target not granted", longint'(busGrant), 0);
        holdBusy[0] = 1'b0;
      end
    join
    check(r9Viol == 0, "R9 grant while busy", r9Viol, 0);
    check(grantSeq[0] == 1 && grantSeq[1] == 0, "R9 service order",
          grantSeq[0] * 16 + grantSeq[1], 16);
    repeat (4) @(negedge clk);

    // R8: slow memory release holds off the next grant
    dropDelay = 5; r8Viol = 0; r8Gap = 0;
    fork
      doRead(0, 2, 7, 0, 0);
      begin
        while (!busGrant[0]) @(negedge clk);
        doRead(1, 1, 8, 0, 0);
      end
    join
    check(r8Viol == 0, "R8 grant during memory release", r8Viol, 0);
    check(r8Gap >= 3, "R8 release window observed", r8Gap, 3);
    dropDelay = 0;
    repeat (4) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule